// File: doc/BRIEF.md
# Mirrored-Sample Folding Preprocessor for a 28-Point DFT

This block takes a complex sequence, one real and one imaginary sample on every rising clock edge, and groups the stream into frames of 28 consecutive samples counted from the release of reset. Once a frame is complete, the block folds it by index symmetry. Each sample y(n) is paired with its mirror y(28-n), and the pair gives a sum term and a difference term. The folded terms are then split by index parity into an even stream and an odd stream. The even sum stream is folded once more into pair sums and pair differences. These are the inputs that a reduced-complexity DFT core needs for its cosine and sine halves when the length is 4·M with M = 7.

Real and imaginary parts are folded independently and in the same way. Every result appears on wide parallel output buses together with a single-cycle done pulse. The buses then hold their values while the next frame is being captured. Each addition level widens the result by one bit, so no result can overflow.

Top module: `dft_fold_pre`

## Requirements
- R1: The block captures one sample (real and imaginary) on every rising clock edge. Frames are 28 consecutive samples: the first frame starts at the first rising edge after reset is released, and each later frame starts on the edge right after the previous frame's last sample.
- R2: `done_o` is high for exactly one cycle, starting right after the second rising edge that follows the edge capturing sample index 27 of a frame. It therefore repeats every 28 cycles.
- R3: Odd stream. For n = 0..6, odd_sum element n = y(2n+1) + y(27-2n) and odd_dif element n = y(2n+1) - y(27-2n). Element n sits at bits [n*13 +: 13].
- R4: Even stream interior. For n = 1..6, even_sum element n = y(2n) + y(28-2n) and even_dif element n = y(2n) - y(28-2n). Element n sits at bits [n*13 +: 13].
- R5: Even stream boundary. even_sum element 0 is y(0) sign-extended, even_dif element 0 is zero, and even_sum element 7 is y(14) sign-extended.
- R6: Second fold. For n = 1..3, pair_sum element n = even_sum(n) + even_sum(7-n) and pair_dif element n = even_sum(n) - even_sum(7-n). Element n sits at bits [(n-1)*14 +: 14].
- R7: All values are two's complement. Samples are 12 bits, first-level results 13 bits and second-level results 14 bits, and none of them wraps at full-scale inputs. Example: all samples at 2047 give a pair_sum of 8188, and all samples at -2048 give -8192.
- R8: Between done pulses every output bus holds its value, including while the next frame is being captured.
- R9: While reset is low, `done_o` is 0 and every output bus is 0. The frame count restarts from sample index 0 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_re_i | input | 12 | Real part of the incoming sample |
| smp_im_i | input | 12 | Imaginary part of the incoming sample |
| even_sum_re_o | output | 104 | Even sum stream, real, elements 0..7 |
| even_sum_im_o | output | 104 | Even sum stream, imaginary, elements 0..7 |
| even_dif_re_o | output | 91 | Even difference stream, real, elements 0..6 |
| even_dif_im_o | output | 91 | Even difference stream, imaginary, elements 0..6 |
| odd_sum_re_o | output | 91 | Odd sum stream, real, elements 0..6 |
| odd_sum_im_o | output | 91 | Odd sum stream, imaginary, elements 0..6 |
| odd_dif_re_o | output | 91 | Odd difference stream, real, elements 0..6 |
| odd_dif_im_o | output | 91 | Odd difference stream, imaginary, elements 0..6 |
| pair_sum_re_o | output | 42 | Second-level sums, real, elements 1..3 |
| pair_sum_im_o | output | 42 | Second-level sums, imaginary, elements 1..3 |
| pair_dif_re_o | output | 42 | Second-level differences, real, elements 1..3 |
| pair_dif_im_o | output | 42 | Second-level differences, imaginary, elements 1..3 |
| done_o | output | 1 | One-cycle pulse marking fresh results |

## Verification
The assertions assume three things about the inputs. The sample stream has no gaps, so the frame position follows from the sample count alone. Reset is applied before the first frame. The frame length is a multiple of four. The stimulus meets these assumptions: it presents a new sample on every cycle and changes inputs only at falling clock edges. It pulls reset only between edges, once in the middle of a frame, and restarts the frame count after release. Full-scale frames (all maximum, all minimum, and split halves) reach the widest sums and differences.

// File: rtl/dft_fold_pkg.sv
package dft_fold_pkg;
  typedef enum logic {FOLD_ADD = 1'b0, FOLD_SUB = 1'b1} fold_op_e;
endpackage

// File: rtl/dft_fold_addsub.sv
module dft_fold_addsub
  import dft_fold_pkg::*;
#(
  parameter int unsigned W  = 12,
  parameter fold_op_e    OP = FOLD_ADD
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   y_o
);
  logic signed [W:0] a_x, b_x, r;
  assign a_x = $signed({a_i[W-1], a_i});
  assign b_x = $signed({b_i[W-1], b_i});

  if (OP == FOLD_ADD) begin : g_add
    assign r = a_x + b_x;
  end else begin : g_sub
    assign r = a_x - b_x;
  end

  assign y_o = r;
endmodule

// File: rtl/dft_fold_capture.sv
module dft_fold_capture #(
  parameter int unsigned N  = 28,
  parameter int unsigned W  = 12,
  localparam int unsigned CW = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    smp_re_i,
  input  logic [W-1:0]    smp_im_i,
  output logic [N*W-1:0]  frm_re_o,
  output logic [N*W-1:0]  frm_im_o,
  output logic            full_o,
  output logic [CW-1:0]   cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [W-1:0]  re_q [N];
  logic [W-1:0]  im_q [N];
  logic [CW-1:0] cnt_q;
  logic          full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      full_q <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  end

  // sample store, no reset needed
  always_ff @(posedge clk_i) begin
    re_q[cnt_q] <= smp_re_i;
    im_q[cnt_q] <= smp_im_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_flat
    assign frm_re_o[i*W +: W] = re_q[i];
    assign frm_im_o[i*W +: W] = im_q[i];
  end

  assign full_o = full_q;
  assign cnt_o  = cnt_q;

  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(N));
  a_r1_frame_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0) && full_q);
  a_r1_full_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |=> !full_q);
endmodule

// File: rtl/dft_fold_level1.sv
module dft_fold_level1
  import dft_fold_pkg::*;
#(
  parameter int unsigned N  = 28,
  parameter int unsigned W  = 12,
  localparam int unsigned M  = N / 4,
  localparam int unsigned AW = W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [N*W-1:0]      frm_i,
  output logic [(M+1)*AW-1:0] a1_o,
  output logic [M*AW-1:0]     b1_o,
  output logic [M*AW-1:0]     a2_o,
  output logic [M*AW-1:0]     b2_o
);
  logic [W-1:0]          y [N];
  logic [(M+1)*AW-1:0]   a1_d, a1_q;
  logic [M*AW-1:0]       b1_d, b1_q, a2_d, a2_q, b2_d, b2_q;

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign y[i] = frm_i[i*W +: W];
  end

  for (genvar n = 0; n < M; n++) begin : g_fold
    // odd stream: index 2n+1 with its mirror
    dft_fold_addsub #(.W(W), .OP(FOLD_ADD)) i_odd_sum (
      .a_i(y[2*n+1]), .b_i(y[N-2*n-1]), .y_o(a2_d[n*AW +: AW]));
    dft_fold_addsub #(.W(W), .OP(FOLD_SUB)) i_odd_dif (
      .a_i(y[2*n+1]), .b_i(y[N-2*n-1]), .y_o(b2_d[n*AW +: AW]));

    if (n == 0) begin : g_even_edge
      assign a1_d[0 +: AW] = {y[0][W-1], y[0]};
      assign b1_d[0 +: AW] = '0;
    end else begin : g_even_mid
      dft_fold_addsub #(.W(W), .OP(FOLD_ADD)) i_even_sum (
        .a_i(y[2*n]), .b_i(y[N-2*n]), .y_o(a1_d[n*AW +: AW]));
      dft_fold_addsub #(.W(W), .OP(FOLD_SUB)) i_even_dif (
        .a_i(y[2*n]), .b_i(y[N-2*n]), .y_o(b1_d[n*AW +: AW]));
    end
  end

  // centre sample has no partner
  assign a1_d[M*AW +: AW] = {y[N/2][W-1], y[N/2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a1_q <= '0;
      b1_q <= '0;
      a2_q <= '0;
      b2_q <= '0;
    end else if (en_i) begin
      a1_q <= a1_d;
      b1_q <= b1_d;
      a2_q <= a2_d;
      b2_q <= b2_d;
    end
  end

  assign a1_o = a1_q;
  assign b1_o = b1_q;
  assign a2_o = a2_q;
  assign b2_o = b2_q;

  a_r8_level1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(a2_q) && $stable(b2_q));
endmodule

// File: rtl/dft_fold_level2.sv
module dft_fold_level2
  import dft_fold_pkg::*;
#(
  parameter int unsigned M  = 7,
  parameter int unsigned AW = 13,
  localparam int unsigned Q  = (M - 1) / 2,
  localparam int unsigned SW = AW + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [(M+1)*AW-1:0] a1_i,
  input  logic [M*AW-1:0]     b1_i,
  input  logic [M*AW-1:0]     a2_i,
  input  logic [M*AW-1:0]     b2_i,
  output logic [(M+1)*AW-1:0] a1_o,
  output logic [M*AW-1:0]     b1_o,
  output logic [M*AW-1:0]     a2_o,
  output logic [M*AW-1:0]     b2_o,
  output logic [Q*SW-1:0]     s_o,
  output logic [Q*SW-1:0]     d_o
);
  logic [Q*SW-1:0]     s_d, d_d, s_q, d_q;
  logic [(M+1)*AW-1:0] a1_q;
  logic [M*AW-1:0]     b1_q, a2_q, b2_q;

  for (genvar n = 1; n <= Q; n++) begin : g_pair
    dft_fold_addsub #(.W(AW), .OP(FOLD_ADD)) i_sum (
      .a_i(a1_i[n*AW +: AW]), .b_i(a1_i[(M-n)*AW +: AW]),
      .y_o(s_d[(n-1)*SW +: SW]));
    dft_fold_addsub #(.W(AW), .OP(FOLD_SUB)) i_dif (
      .a_i(a1_i[n*AW +: AW]), .b_i(a1_i[(M-n)*AW +: AW]),
      .y_o(d_d[(n-1)*SW +: SW]));
  end

  // first-level terms re-registered so all buses switch on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a1_q <= '0;
      b1_q <= '0;
      a2_q <= '0;
      b2_q <= '0;
      s_q  <= '0;
      d_q  <= '0;
    end else if (en_i) begin
      a1_q <= a1_i;
      b1_q <= b1_i;
      a2_q <= a2_i;
      b2_q <= b2_i;
      s_q  <= s_d;
      d_q  <= d_d;
    end
  end

  assign a1_o = a1_q;
  assign b1_o = b1_q;
  assign a2_o = a2_q;
  assign b2_o = b2_q;
  assign s_o  = s_q;
  assign d_o  = d_q;

  a_r6_even_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> a1_q == $past(a1_i));
endmodule

// File: rtl/dft_fold_pre.sv
module dft_fold_pre #(
  parameter int unsigned N_PTS  = 28,
  parameter int unsigned DATA_W = 12,
  localparam int unsigned M  = N_PTS / 4,
  localparam int unsigned AW = DATA_W + 1,
  localparam int unsigned SW = DATA_W + 2,
  localparam int unsigned Q  = (M - 1) / 2,
  localparam int unsigned CW = $clog2(N_PTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   smp_re_i,
  input  logic [DATA_W-1:0]   smp_im_i,
  output logic [(M+1)*AW-1:0] even_sum_re_o,
  output logic [(M+1)*AW-1:0] even_sum_im_o,
  output logic [M*AW-1:0]     even_dif_re_o,
  output logic [M*AW-1:0]     even_dif_im_o,
  output logic [M*AW-1:0]     odd_sum_re_o,
  output logic [M*AW-1:0]     odd_sum_im_o,
  output logic [M*AW-1:0]     odd_dif_re_o,
  output logic [M*AW-1:0]     odd_dif_im_o,
  output logic [Q*SW-1:0]     pair_sum_re_o,
  output logic [Q*SW-1:0]     pair_sum_im_o,
  output logic [Q*SW-1:0]     pair_dif_re_o,
  output logic [Q*SW-1:0]     pair_dif_im_o,
  output logic                done_o
);
  localparam logic [CW-1:0] DONE_CNT = CW'(2 % N_PTS);

  logic [N_PTS*DATA_W-1:0] frm_re, frm_im;
  logic                    full;
  logic [CW-1:0]           cap_cnt;
  logic                    lvl1_v_q, done_q;

  logic [(M+1)*AW-1:0] a1_re, a1_im;
  logic [M*AW-1:0]     b1_re, b1_im, a2_re, a2_im, b2_re, b2_im;

  dft_fold_capture #(.N(N_PTS), .W(DATA_W)) i_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_re_i (smp_re_i),
    .smp_im_i (smp_im_i),
    .frm_re_o (frm_re),
    .frm_im_o (frm_im),
    .full_o   (full),
    .cnt_o    (cap_cnt)
  );

  dft_fold_level1 #(.N(N_PTS), .W(DATA_W)) i_lvl1_re (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(full), .frm_i(frm_re),
    .a1_o(a1_re), .b1_o(b1_re), .a2_o(a2_re), .b2_o(b2_re));

  dft_fold_level1 #(.N(N_PTS), .W(DATA_W)) i_lvl1_im (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(full), .frm_i(frm_im),
    .a1_o(a1_im), .b1_o(b1_im), .a2_o(a2_im), .b2_o(b2_im));

  dft_fold_level2 #(.M(M), .AW(AW)) i_lvl2_re (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(lvl1_v_q),
    .a1_i(a1_re), .b1_i(b1_re), .a2_i(a2_re), .b2_i(b2_re),
    .a1_o(even_sum_re_o), .b1_o(even_dif_re_o),
    .a2_o(odd_sum_re_o), .b2_o(odd_dif_re_o),
    .s_o(pair_sum_re_o), .d_o(pair_dif_re_o));

  dft_fold_level2 #(.M(M), .AW(AW)) i_lvl2_im (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(lvl1_v_q),
    .a1_i(a1_im), .b1_i(b1_im), .a2_i(a2_im), .b2_i(b2_im),
    .a1_o(even_sum_im_o), .b1_o(even_dif_im_o),
    .a2_o(odd_sum_im_o), .b2_o(odd_dif_im_o),
    .s_o(pair_sum_im_o), .d_o(pair_dif_im_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl1_v_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      lvl1_v_q <= full;
      done_q   <= lvl1_v_q;
    end
  end

  assign done_o = done_q;

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_done_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cap_cnt == DONE_CNT);
  a_r8_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(pair_sum_re_o) && $stable(pair_dif_im_o)
                && $stable(even_sum_re_o) && $stable(odd_dif_im_o));
endmodule

// File: tb/test_dft_fold_pre.sv
module test_dft_fold_pre;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 28;
  localparam int W  = 12;
  localparam int M  = 7;
  localparam int AW = 13;
  localparam int SW = 14;

  logic clk_i = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] smp_re = '0, smp_im = '0;
  logic [(M+1)*AW-1:0] es_re, es_im;
  logic [M*AW-1:0] ed_re, ed_im, os_re, os_im, od_re, od_im;
  logic [3*SW-1:0] ps_re, ps_im, pd_re, pd_im;
  logic done_o;

  int total = 0, bad = 0;
  bit fin = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dft_fold_pre i_dft_fold_pre (
    .clk_i(clk_i), .rst_ni(rst_n), .smp_re_i(smp_re), .smp_im_i(smp_im),
    .even_sum_re_o(es_re), .even_sum_im_o(es_im),
    .even_dif_re_o(ed_re), .even_dif_im_o(ed_im),
    .odd_sum_re_o(os_re), .odd_sum_im_o(os_im),
    .odd_dif_re_o(od_re), .odd_dif_im_o(od_im),
    .pair_sum_re_o(ps_re), .pair_sum_im_o(ps_im),
    .pair_dif_re_o(pd_re), .pair_dif_im_o(pd_im),
    .done_o(done_o));

  // reference model state
  int fr[2][NP];
  int mcnt = 0, pend_cnt = 0, cur_kind = 0, pend_kind = 0, exp_kind = 0;
  bit exp_done = 0;
  int pa1[2][8], pb1[2][7], pa2[2][7], pb2[2][7], ps[2][3], pd[2][3];
  int xa1[2][8], xb1[2][7], xa2[2][7], xb2[2][7], xs[2][3], xd[2][3];

  initial begin
    foreach (xa1[c, i]) xa1[c][i] = 0;
    foreach (xb1[c, i]) begin xb1[c][i] = 0; xa2[c][i] = 0; xb2[c][i] = 0; end
    foreach (xs[c, i]) begin xs[c][i] = 0; xd[c][i] = 0; end
  end

  always @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mcnt = 0; pend_cnt = 0; exp_done = 0;
      foreach (xa1[c, i]) xa1[c][i] = 0;
      foreach (xb1[c, i]) begin xb1[c][i] = 0; xa2[c][i] = 0; xb2[c][i] = 0; end
      foreach (xs[c, i]) begin xs[c][i] = 0; xd[c][i] = 0; end
    end else begin
      exp_done = 0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          xa1 = pa1; xb1 = pb1; xa2 = pa2; xb2 = pb2; xs = ps; xd = pd;
          exp_done = 1; exp_kind = pend_kind;
        end
      end
      fr[0][mcnt] = int'($signed(smp_re));
      fr[1][mcnt] = int'($signed(smp_im));
      if (mcnt == NP-1) begin
        for (int c = 0; c < 2; c++) begin
          pa1[c][0] = fr[c][0]; pb1[c][0] = 0; pa1[c][7] = fr[c][14];
          for (int n = 1; n < 7; n++) begin
            pa1[c][n] = fr[c][2*n] + fr[c][NP-2*n];
            pb1[c][n] = fr[c][2*n] - fr[c][NP-2*n];
          end
          for (int n = 0; n < 7; n++) begin
            pa2[c][n] = fr[c][2*n+1] + fr[c][NP-1-2*n];
            pb2[c][n] = fr[c][2*n+1] - fr[c][NP-1-2*n];
          end
          for (int n = 1; n <= 3; n++) begin
            ps[c][n-1] = pa1[c][n] + pa1[c][7-n];
            pd[c][n-1] = pa1[c][n] - pa1[c][7-n];
          end
        end
        pend_kind = cur_kind; pend_cnt = 2; mcnt = 0;
      end else mcnt++;
    end
  end

  function automatic int fld(input logic [127:0] v, input int i, input int w);
    logic [127:0] sh;
    int r;
    sh = v >> (i*w);
    r = int'(sh[31:0]);
    r = (r <<< (32-w)) >>> (32-w);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d @%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string t;
    for (int c = 0; c < 2; c++) begin
      logic [127:0] va1, vb1, va2, vb2, vs, vd;
      int act, exp;
      bit ok;
      va1 = 128'(c ? es_im : es_re); vb1 = 128'(c ? ed_im : ed_re);
      va2 = 128'(c ? os_im : os_re); vb2 = 128'(c ? od_im : od_re);
      vs  = 128'(c ? ps_im : ps_re); vd  = 128'(c ? pd_im : pd_re);
      // R5 boundary
      t = exp_done ? "R5" : "R8";
      ok = 1; act = 0; exp = 0;
      if (fld(va1, 0, AW) != xa1[c][0]) begin ok = 0; act = fld(va1, 0, AW); exp = xa1[c][0]; end
      else if (fld(vb1, 0, AW) != 0) begin ok = 0; act = fld(vb1, 0, AW); exp = 0; end
      else if (fld(va1, 7, AW) != xa1[c][7]) begin ok = 0; act = fld(va1, 7, AW); exp = xa1[c][7]; end
      chk(ok, t, c ? "even boundary im" : "even boundary re", act, exp);
      // R4 even interior
      t = exp_done ? "R4" : "R8";
      ok = 1; act = 0; exp = 0;
      for (int n = 1; n < 7; n++) begin
        if (ok && fld(va1, n, AW) != xa1[c][n]) begin ok = 0; act = fld(va1, n, AW); exp = xa1[c][n]; end
        if (ok && fld(vb1, n, AW) != xb1[c][n]) begin ok = 0; act = fld(vb1, n, AW); exp = xb1[c][n]; end
      end
      chk(ok, t, c ? "even stream im" : "even stream re", act, exp);
      // R3 odd stream
      t = exp_done ? "R3" : "R8";
      ok = 1; act = 0; exp = 0;
      for (int n = 0; n < 7; n++) begin
        if (ok && fld(va2, n, AW) != xa2[c][n]) begin ok = 0; act = fld(va2, n, AW); exp = xa2[c][n]; end
        if (ok && fld(vb2, n, AW) != xb2[c][n]) begin ok = 0; act = fld(vb2, n, AW); exp = xb2[c][n]; end
      end
      chk(ok, t, c ? "odd stream im" : "odd stream re", act, exp);
      // R6 second fold
      t = exp_done ? "R6" : "R8";
      ok = 1; act = 0; exp = 0;
      for (int n = 0; n < 3; n++) begin
        if (ok && fld(vs, n, SW) != xs[c][n]) begin ok = 0; act = fld(vs, n, SW); exp = xs[c][n]; end
        if (ok && fld(vd, n, SW) != xd[c][n]) begin ok = 0; act = fld(vd, n, SW); exp = xd[c][n]; end
      end
      chk(ok, t, c ? "pair terms im" : "pair terms re", act, exp);
    end
    // R2 done timing, which also fixes the R1 frame alignment
    chk(done_o == exp_done, "R2", "done pulse (R1 framing)", int'(done_o), int'(exp_done));
    // R7 full-scale values
    if (exp_done && exp_kind == 1)
      chk(fld(128'(ps_re), 0, SW) == 8188, "R7", "max pair sum", fld(128'(ps_re), 0, SW), 8188);
    if (exp_done && exp_kind == 2)
      chk(fld(128'(ps_im), 2, SW) == -8192, "R7", "min pair sum", fld(128'(ps_im), 2, SW), -8192);
    if (exp_done && exp_kind == 3)
      chk(fld(128'(od_re), 0, AW) == 4095, "R7", "max odd diff", fld(128'(od_re), 0, AW), 4095);
  endtask

  function automatic int gen(input int kind, input int idx, input int c);
    case (kind)
      0: return int'($urandom_range(0, 4095)) - 2048;
      1: return 2047;
      2: return -2048;
      3: return ((idx < 14) ^ (c == 1)) ? 2047 : -2048;
      4: return idx*137 - 1800 + c*50;
      5: return c ? -2048 : 2047;
      default: return 0;
    endcase
  endfunction

  task automatic step(input int kind, input int idx);
    smp_re = W'(gen(kind, idx, 0));
    smp_im = W'(gen(kind, idx, 1));
    @(negedge clk_i);
    compare();
  endtask

  task automatic reset_check();
    @(negedge clk_i);
    compare();
    chk(done_o == 0 && es_re == '0 && pd_im == '0 && os_im == '0, "R9",
        "outputs cleared in reset", int'(done_o), 0);
  endtask

  initial begin
    int kinds_a[8] = '{0, 1, 2, 3, 4, 0, 5, 0};
    int kinds_b[3] = '{4, 0, 1};
    repeat (3) reset_check();
    rst_n = 1'b1;
    foreach (kinds_a[f]) begin
      cur_kind = kinds_a[f];
      for (int i = 0; i < NP; i++) step(kinds_a[f], i);
    end
    cur_kind = 0;
    for (int i = 0; i < 10; i++) step(0, i);
    rst_n = 1'b0;
    repeat (2) reset_check();
    rst_n = 1'b1;
    foreach (kinds_b[f]) begin
      cur_kind = kinds_b[f];
      for (int i = 0; i < NP; i++) step(kinds_b[f], i);
    end
    cur_kind = 6;
    for (int i = 0; i < 4; i++) step(6, i);
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule